// File: doc/BRIEF.md
# Overcurrent Hiccup Controller

This block sits beside the switching controller of a step-down converter. It watches the high-side current limit across switching periods and decides when an overload has lasted long enough to shut the converter down. Each current-limit event is counted. A run of clean switching periods clears the count. When the count reaches its terminal value, the block holds both power switches off and discharges the soft-start node. It then waits a fixed number of oscillator periods. At the end of that wait it issues a one-cycle restart request, so the converter begins a fresh soft-start.

The block uses four named states:
- `ST_IDLE`: the converter is disabled.
- `ST_RUN`: normal switching, with overload detection active. Detection also covers the soft-start ramp.
- `ST_WAIT`: the hiccup idle interval.
- `ST_KICK`: the single cycle that carries the restart request.

The transitions are:
- `ST_IDLE` to `ST_RUN` when enable is high.
- `ST_RUN` to `ST_WAIT` on the terminal event (trip).
- `ST_WAIT` to `ST_KICK` when the timeout expires.
- `ST_KICK` to `ST_RUN` unconditionally.
- Any state to `ST_IDLE` when enable is low. This transition has priority over all others.

A switching period is the interval from one `osc_tick` to the next. A turn-on strobe (`hs_on`) that arrives together with a tick belongs to the period that the tick opens. A limit flag (`ilim`) that arrives together with a tick belongs to the period that the tick closes.

Top module: `hc_ctrl`

## Requirements
- R1: After reset, and whenever `en` is low, the block is in `ST_IDLE` with `sw_off`=1, `ss_dischg`=0 and `restart`=0. `en` low takes effect at the next clock edge from any state, including the hiccup wait. It clears all counters. Raising `en` again returns to `ST_RUN` (`sw_off`=0) without a restart pulse.
- R2: In `ST_RUN`, each cycle with `ilim`=1 counts one event. The eighth event counted since the last clear moves the block to `ST_WAIT` at that clock edge. From the next edge onward, `sw_off`=1 and `ss_dischg`=1.
- R3: The event counter is 3 bits wide and does not wrap. Seven events without a clear leave `sw_off`=0.
- R4: A period is clean when it contains an `hs_on` strobe and no `ilim`. Three consecutive clean periods clear the event count, and the count is cleared at the tick that closes the third clean period. Two clean periods do not clear it.
- R5: Any `ilim` resets the clean-period run to zero.
- R6: A period without an `hs_on` strobe does not count as clean. It neither advances nor breaks the clean run.
- R7: An `ilim` in the same cycle as the closing tick makes the closing period not clean, and that `ilim` is counted as an event.
- R8: The hiccup wait lasts `TIMEOUT` (default 1024) ticks. In the cycle after the edge that samples the last tick, the block shows `restart`=1, `sw_off`=1 and `ss_dischg`=0 for exactly one cycle. After that cycle it shows `sw_off`=0.
- R9: `hs_on` and `ilim` are ignored during the wait. After the restart, the event count starts from zero and detection is active again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Converter enable |
| hs_on | input | 1 | One-cycle strobe marking a high-side turn-on |
| ilim | input | 1 | High-side current-limit event flag |
| osc_tick | input | 1 | One-cycle strobe at each oscillator period boundary |
| sw_off | output | 1 | Holds both power switches off |
| ss_dischg | output | 1 | Discharge command for the soft-start node |
| restart | output | 1 | One-cycle request to begin a new soft-start |

## Verification
The two functions that can fall in the same cycle are:
- closing a period, which may complete the clean run and clear the event count;
- counting a new limit event.

The bench provokes this overlap as follows. It builds up two clean periods, follows them with a third period that holds a turn-on, and raises `ilim` exactly on the tick that closes that third period. The design is judged correct only if the period is not treated as clean and the event is counted. This is checked by the block tripping on exactly the eighth total event and not one event later.

// File: rtl/hc_pkg.sv
package hc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_WAIT,
        ST_KICK
    } hc_state_t;
endpackage

// File: rtl/hc_clean_run.sv
module hc_clean_run #(
    parameter int RUN_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic hs_on,
    input  logic ilim,
    input  logic osc_tick,
    output logic run_done
);
    localparam int CLEAN_W = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1;
    localparam logic [CLEAN_W-1:0] LAST = CLEAN_W'(RUN_LEN - 1);

    logic               turned_on;
    logic               limited;
    logic [CLEAN_W-1:0] clean_cnt;
    logic               period_clean;

    // a period closes at the tick; an ilim on that tick belongs to it
    assign period_clean = osc_tick && turned_on && !limited && !ilim;
    assign run_done     = !clr && period_clean && (clean_cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            turned_on <= 1'b0;
            limited   <= 1'b0;
            clean_cnt <= '0;
        end else if (clr) begin
            turned_on <= 1'b0;
            limited   <= 1'b0;
            clean_cnt <= '0;
        end else if (osc_tick) begin
            turned_on <= hs_on;
            limited   <= 1'b0;
            if (ilim) begin
                clean_cnt <= '0;
            end else if (period_clean) begin
                clean_cnt <= (clean_cnt == LAST) ? '0 : clean_cnt + 1'b1;
            end
        end else begin
            if (hs_on) begin
                turned_on <= 1'b1;
            end
            if (ilim) begin
                limited   <= 1'b1;
                clean_cnt <= '0;
            end
        end
    end
endmodule

// File: rtl/hc_evt_cnt.sv
module hc_evt_cnt #(
    parameter int EVT_W = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run_done,
    input  logic ilim,
    output logic trip
);
    localparam logic [EVT_W-1:0] TERM = {EVT_W{1'b1}};

    logic [EVT_W-1:0] evt_cnt;

    assign trip = !clr && ilim && (evt_cnt == TERM);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_cnt <= '0;
        end else if (clr) begin
            evt_cnt <= '0;
        end else if (ilim) begin
            if (!trip) begin
                evt_cnt <= evt_cnt + 1'b1;
            end
        end else if (run_done) begin
            evt_cnt <= '0;
        end
    end
endmodule

// File: rtl/hc_tmr.sv
module hc_tmr #(
    parameter int TIMEOUT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic osc_tick,
    output logic done
);
    localparam int TMR_W = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
    localparam logic [TMR_W-1:0] LAST = TMR_W'(TIMEOUT - 1);

    logic [TMR_W-1:0] tick_cnt;

    assign done = !clr && osc_tick && (tick_cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_cnt <= '0;
        end else if (clr) begin
            tick_cnt <= '0;
        end else if (osc_tick && !done) begin
            tick_cnt <= tick_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/hc_ctrl.sv
module hc_ctrl
    import hc_pkg::*;
#(
    parameter int EVT_W   = 3,
    parameter int RUN_LEN = 3,
    parameter int TIMEOUT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic hs_on,
    input  logic ilim,
    input  logic osc_tick,
    output logic sw_off,
    output logic ss_dischg,
    output logic restart
);
    hc_state_t state;
    hc_state_t state_nx;
    logic      cnt_clr;
    logic      tmr_clr;
    logic      run_done;
    logic      trip;
    logic      tmo_done;

    assign cnt_clr = (state != ST_RUN);
    assign tmr_clr = (state != ST_WAIT);

    hc_clean_run #(.RUN_LEN(RUN_LEN)) u_run (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cnt_clr),
        .hs_on    (hs_on),
        .ilim     (ilim),
        .osc_tick (osc_tick),
        .run_done (run_done)
    );

    hc_evt_cnt #(.EVT_W(EVT_W)) u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cnt_clr),
        .run_done (run_done),
        .ilim     (ilim),
        .trip     (trip)
    );

    hc_tmr #(.TIMEOUT(TIMEOUT)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (tmr_clr),
        .osc_tick (osc_tick),
        .done     (tmo_done)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (en) state_nx = ST_RUN;
            ST_RUN:  if (!en) state_nx = ST_IDLE;
                     else if (trip) state_nx = ST_WAIT;
            ST_WAIT: if (!en) state_nx = ST_IDLE;
                     else if (tmo_done) state_nx = ST_KICK;
            ST_KICK: if (!en) state_nx = ST_IDLE;
                     else state_nx = ST_RUN;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        sw_off    = 1'b1;
        ss_dischg = 1'b0;
        restart   = 1'b0;
        unique case (state)
            ST_IDLE: sw_off = 1'b1;
            ST_RUN:  sw_off = 1'b0;
            ST_WAIT: ss_dischg = 1'b1;
            ST_KICK: restart = 1'b1;
            default: sw_off = 1'b1;
        endcase
    end
endmodule

// File: rtl/hc_ctrl_chk.sv
module hc_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic ilim,
    input logic osc_tick,
    input logic sw_off,
    input logic ss_dischg,
    input logic restart
);
    // R8
    restart_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !restart);

    // R8
    restart_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |-> $past(osc_tick));

    // R2
    dischg_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ss_dischg |-> sw_off);

    // R1
    disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (sw_off && !ss_dischg && !restart));

    // R2
    trip_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ss_dischg) |-> $past(ilim));

    // R8
    dischg_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ss_dischg) |-> (restart || !$past(en)));
endmodule

bind hc_ctrl hc_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .ilim      (ilim),
    .osc_tick  (osc_tick),
    .sw_off    (sw_off),
    .ss_dischg (ss_dischg),
    .restart   (restart)
);

// File: tb/hc_ctrl_test.sv
module hc_ctrl_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic hs_on = 1'b0;
    logic ilim = 1'b0;
    logic osc_tick = 1'b0;
    logic sw_off, ss_dischg, restart;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        string req;
        logic  off;
        logic  dis;
        logic  rs;
    } exp_t;
    exp_t q[$];

    always #4 clk = ~clk;

    hc_ctrl uut (
        .clk(clk), .rst_n(rst_n), .en(en), .hs_on(hs_on), .ilim(ilim),
        .osc_tick(osc_tick), .sw_off(sw_off), .ss_dischg(ss_dischg),
        .restart(restart)
    );

    task automatic cyc(input logic t, input logic h, input logic i);
        @(negedge clk);
        osc_tick = t;
        hs_on    = h;
        ilim     = i;
    endtask

    task automatic expect_out(input string req, input logic off,
                              input logic dis, input logic rs);
        exp_t e;
        e.req = req; e.off = off; e.dis = dis; e.rs = rs;
        q.push_back(e);
    endtask

    task automatic period(input logic h, input logic i);
        cyc(1'b1, h, 1'b0);
        cyc(1'b0, 1'b0, i);
        cyc(1'b0, 1'b0, 1'b0);
        cyc(1'b0, 1'b0, 1'b0);
    endtask

    task automatic events(input int n);
        for (int k = 0; k < n; k++) period(1'b1, 1'b1);
    endtask

    task automatic cleans(input int n);
        for (int k = 0; k < n; k++) period(1'b1, 1'b0);
    endtask

    task automatic set_en(input logic v);
        @(negedge clk);
        osc_tick = 1'b0; hs_on = 1'b0; ilim = 1'b0;
        en = v;
    endtask

    task automatic recover;
        set_en(1'b0);
        expect_out("R1", 1'b1, 1'b0, 1'b0);
        set_en(1'b1);
        expect_out("R1", 1'b0, 1'b0, 1'b0);
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                e = q.pop_front();
                n_chk++;
                if (sw_off !== e.off || ss_dischg !== e.dis || restart !== e.rs) begin
                    n_bad++;
                    $display("FAIL %s: off/dis/rs actual %b%b%b expected %b%b%b at %0t",
                             e.req, sw_off, ss_dischg, restart, e.off, e.dis, e.rs, $time);
                end
            end
        end
    end

    initial begin : watchdog
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : driver
        // R1 reset state
        repeat (2) @(negedge clk);
        expect_out("R1", 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        set_en(1'b1);
        expect_out("R1", 1'b0, 1'b0, 1'b0);

        // R3 seven events do not trip; R2 the eighth does
        events(7);
        expect_out("R3", 1'b0, 1'b0, 1'b0);
        events(1);
        expect_out("R2", 1'b1, 1'b1, 1'b0);

        // R8 timeout, with R9 inputs active during the wait
        for (int k = 0; k < 1023; k++) period(1'b1, 1'b1);
        expect_out("R8", 1'b1, 1'b1, 1'b0);
        cyc(1'b1, 1'b0, 1'b0);
        expect_out("R8", 1'b1, 1'b0, 1'b1);
        cyc(1'b0, 1'b0, 1'b0);
        expect_out("R8", 1'b0, 1'b0, 1'b0);
        cyc(1'b0, 1'b0, 1'b0);
        cyc(1'b0, 1'b0, 1'b0);

        // R9 counter fresh after restart, detection active
        events(7);
        expect_out("R9", 1'b0, 1'b0, 1'b0);
        events(1);
        expect_out("R9", 1'b1, 1'b1, 1'b0);

        // R1 enable low leaves hiccup at once, no restart pulse
        recover();

        // R4 three clean periods clear the count
        events(5);
        cleans(3);
        events(7);
        expect_out("R4", 1'b0, 1'b0, 1'b0);
        events(1);
        expect_out("R4", 1'b1, 1'b1, 1'b0);
        recover();

        // R4 two clean periods do not clear
        events(5);
        cleans(2);
        events(2);
        expect_out("R4", 1'b0, 1'b0, 1'b0);
        events(1);
        expect_out("R4", 1'b1, 1'b1, 1'b0);
        recover();

        // R5 an event resets the clean run
        events(4);
        cleans(2);
        events(1);
        cleans(2);
        events(2);
        expect_out("R5", 1'b0, 1'b0, 1'b0);
        events(1);
        expect_out("R5", 1'b1, 1'b1, 1'b0);
        recover();

        // R6 periods without turn-on are not clean
        events(5);
        for (int k = 0; k < 3; k++) period(1'b0, 1'b0);
        events(2);
        expect_out("R6", 1'b0, 1'b0, 1'b0);
        events(1);
        expect_out("R6", 1'b1, 1'b1, 1'b0);
        recover();

        // R6 periods without turn-on do not break the run
        events(5);
        cleans(2);
        period(1'b0, 1'b0);
        cleans(1);
        events(7);
        expect_out("R6", 1'b0, 1'b0, 1'b0);
        events(1);
        expect_out("R6", 1'b1, 1'b1, 1'b0);
        recover();

        // R7 ilim on the closing tick of a would-be third clean period
        events(5);
        cleans(2);
        cyc(1'b1, 1'b1, 1'b0);
        cyc(1'b0, 1'b0, 1'b0);
        cyc(1'b0, 1'b0, 1'b0);
        cyc(1'b0, 1'b0, 1'b0);
        cyc(1'b1, 1'b0, 1'b1);
        cyc(1'b0, 1'b0, 1'b0);
        cyc(1'b0, 1'b0, 1'b0);
        cyc(1'b0, 1'b0, 1'b0);
        events(1);
        expect_out("R7", 1'b0, 1'b0, 1'b0);
        events(1);
        expect_out("R7", 1'b1, 1'b1, 1'b0);
        recover();

        // R1 enable low mid-count clears the counter
        events(5);
        recover();
        events(7);
        expect_out("R1", 1'b0, 1'b0, 1'b0);
        events(1);
        expect_out("R1", 1'b1, 1'b1, 1'b0);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule